// File: doc/BRIEF.md
# AXI4-Lite Byte Stream Bridge

This block is a memory-mapped slave that lets a host processor exchange bytes with a byte-oriented command engine. On the host side it presents an AXI4-Lite slave port. On the engine side it presents two byte streams with valid/ready handshakes: an outbound stream that carries bytes to the engine, and an inbound stream that collects the engine's reply bytes. Each direction is decoupled by its own FIFO, and each FIFO depth is a parameter.

The host writes a byte register to queue an outbound byte, and polls a status register to see whether there is room. It reads a data register to take the oldest inbound byte, and polls a second status register to see whether one is waiting. Three more words complete the map. The first is a read-only identification word set by a parameter. The second is a 32-bit scratch word for bus sanity tests. The third is a read-only word giving the number of engine cores, also set by a parameter. The write address and write data channels may complete in either order, and only one write and one read are in flight at a time.

Top module: `axil_byte_bridge`

## Requirements
- R1: After reset `s_bvalid`, `s_rvalid` and `tx_valid` are low, and `s_awready`, `s_wready`, `s_arready` and `rx_ready` are high.
- R2: The write address and write data handshakes may complete in either order or in the same cycle. `s_bvalid` rises only after both have completed. It then holds, with `s_bresp` stable, until `s_bready` is seen. `s_awready` and `s_wready` stay low while a response is pending.
- R3: A write to byte offset 0x000 appends `s_wdata[7:0]` to the outbound FIFO and returns OKAY (2'b00). If the FIFO is full, the byte is dropped and the response is SLVERR (2'b10).
- R4: `tx_valid` is high exactly when the outbound FIFO holds a byte. `tx_byte` is the oldest queued byte, and it is removed on a cycle where `tx_valid` and `tx_ready` are both high. Bytes leave in the order they were written.
- R5: A read of offset 0x004 returns bit 0 = 1 when the outbound FIFO has room for another byte. All other bits read zero.
- R6: `rx_ready` is high while the inbound FIFO has room. A byte on `rx_byte` is stored on each cycle where `rx_valid` and `rx_ready` are both high.
- R7: A read of offset 0x008 removes the oldest inbound byte and returns it in bits 7:0, with zero above. When the inbound FIFO is empty, the read returns zero and removes nothing.
- R8: A read of offset 0x00C returns bit 0 = 1 when at least one inbound byte is waiting. All other bits read zero.
- R9: Offset 0x014 reads the `ID_WORD` parameter. A write there changes nothing and returns OKAY.
- R10: Offset 0x018 is a read/write scratch word that resets to zero. Write data lands only in the byte lanes whose `s_wstrb` bit is set.
- R11: Offset 0x01C reads the `CORE_COUNT` parameter.
- R12: Address bits 1:0 are ignored in decoding. Any other offset reads zero, ignores writes, and responds OKAY.
- R13: Reads respond OKAY. `s_arready` is low while `s_rvalid` is high. `s_rvalid` and `s_rdata` hold until `s_rready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| tx_byte | output | 8 | Outbound byte to the engine |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Engine accepts outbound byte |
| rx_byte | input | 8 | Inbound byte from the engine |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Bridge accepts inbound byte |

## Verification
The bench builds the bridge with both FIFO depths set to 4, a non-default identification word (0xC0DE0207) and a core count of 6. With depth 4, a handful of writes fills the outbound FIFO, so the SLVERR drop path, the zero status bit and the drain order can all be reached within a few dozen cycles. Six back-to-back inbound bytes overrun the inbound FIFO, which exercises the dropped-byte path and the empty-read-returns-zero case. The non-default parameter values show that the identification and core-count words track their parameters rather than a fixed constant.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int BUS_W  = 32;
  localparam int STRB_W = BUS_W / 8;

  typedef logic [1:0] axi_resp_t;
  localparam axi_resp_t RESP_OKAY   = 2'b00;
  localparam axi_resp_t RESP_SLVERR = 2'b10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TX_BYTE,
    SEL_TX_STAT,
    SEL_RX_BYTE,
    SEL_RX_STAT,
    SEL_IDENT,
    SEL_SCRATCH,
    SEL_CORES
  } reg_sel_t;

  // Word decode; the two lowest address bits never take part.
  function automatic reg_sel_t decode_offset(input logic [31:0] byte_addr);
    logic [31:0] word_addr;
    word_addr = {byte_addr[31:2], 2'b00};
    case (word_addr)
      32'h000: decode_offset = SEL_TX_BYTE;
      32'h004: decode_offset = SEL_TX_STAT;
      32'h008: decode_offset = SEL_RX_BYTE;
      32'h00C: decode_offset = SEL_RX_STAT;
      32'h014: decode_offset = SEL_IDENT;
      32'h018: decode_offset = SEL_SCRATCH;
      32'h01C: decode_offset = SEL_CORES;
      default: decode_offset = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bridge_byte_fifo.sv
module bridge_byte_fifo #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_byte,
  input  logic       pop,
  output logic [7:0] head_byte,
  output logic       full,
  output logic       empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q,  count_d;

  assign full      = (count_q == FULL_CNT);
  assign empty     = (count_q == '0);
  assign head_byte = store[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // Storage carries no reset; only written slots are ever read out.
  always_ff @(posedge clk) begin
    if (push) begin
      store[wr_ptr_q] <= push_byte;
    end
  end

  // R3 / R6: callers never push into a full FIFO
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R7 / R4: callers never pop an empty FIFO
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R4: occupancy never exceeds the depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);

endmodule

// File: rtl/bridge_wr_chan.sv
module bridge_wr_chan
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output axi_resp_t         bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              cmd_en,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BUS_W-1:0]  cmd_data,
  output logic [STRB_W-1:0] cmd_strb,
  input  axi_resp_t         cmd_resp
);

  logic              addr_held_q, addr_held_d;
  logic              data_held_q, data_held_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BUS_W-1:0]  data_q, data_d;
  logic [STRB_W-1:0] strb_q, strb_d;
  logic              bvalid_q, bvalid_d;
  axi_resp_t         bresp_q, bresp_d;
  logic              addr_take, data_take;

  assign awready   = !addr_held_q && !bvalid_q;
  assign wready    = !data_held_q && !bvalid_q;
  assign addr_take = awvalid && awready;
  assign data_take = wvalid && wready;
  assign cmd_en    = addr_held_q && data_held_q;
  assign cmd_addr  = addr_q;
  assign cmd_data  = data_q;
  assign cmd_strb  = strb_q;
  assign bvalid    = bvalid_q;
  assign bresp     = bresp_q;

  always_comb begin
    addr_held_d = addr_held_q;
    data_held_d = data_held_q;
    addr_d      = addr_q;
    data_d      = data_q;
    strb_d      = strb_q;
    bvalid_d    = bvalid_q;
    bresp_d     = bresp_q;
    if (addr_take) begin
      addr_held_d = 1'b1;
      addr_d      = awaddr;
    end
    if (data_take) begin
      data_held_d = 1'b1;
      data_d      = wdata;
      strb_d      = wstrb;
    end
    if (cmd_en) begin
      addr_held_d = 1'b0;
      data_held_d = 1'b0;
      bvalid_d    = 1'b1;
      bresp_d     = cmd_resp;
    end else if (bvalid_q && bready) begin
      bvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_held_q <= 1'b0;
      data_held_q <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      strb_q      <= '0;
      bvalid_q    <= 1'b0;
      bresp_q     <= RESP_OKAY;
    end else begin
      addr_held_q <= addr_held_d;
      data_held_q <= data_held_d;
      addr_q      <= addr_d;
      data_q      <= data_d;
      strb_q      <= strb_d;
      bvalid_q    <= bvalid_d;
      bresp_q     <= bresp_d;
    end
  end

  // R2: response held with a stable code until accepted
  a_r2_bresp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && $stable(bresp));
  // R2: no new write accepted while a response is pending
  a_r2_no_take_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready && !wready);
  // R2: a response appears only after a write executed
  a_r2_bvalid_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> $past(cmd_en));

endmodule

// File: rtl/bridge_rd_chan.sv
module bridge_rd_chan
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [BUS_W-1:0]  rdata,
  output axi_resp_t         rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              req_en,
  output logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_data
);

  logic             rvalid_q, rvalid_d;
  logic [BUS_W-1:0] rdata_q,  rdata_d;

  assign arready  = !rvalid_q;
  assign req_en   = arvalid && arready;
  assign req_addr = araddr;
  assign rvalid   = rvalid_q;
  assign rdata    = rdata_q;
  assign rresp    = RESP_OKAY;

  always_comb begin
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (req_en) begin
      rvalid_d = 1'b1;
      rdata_d  = req_data;
    end else if (rvalid_q && rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  // R13: read data held until accepted
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R13: one read outstanding at a time
  a_r13_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready);

endmodule

// File: rtl/axil_byte_bridge.sv
module axil_byte_bridge
  import bridge_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          TX_DEPTH   = 32,
  parameter int          RX_DEPTH   = 32,
  parameter logic [31:0] ID_WORD    = 32'hF202_0380,
  parameter logic [31:0] CORE_COUNT = 32'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready
);

  logic              cmd_en;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BUS_W-1:0]  cmd_data;
  logic [STRB_W-1:0] cmd_strb;
  axi_resp_t         cmd_resp;
  logic              req_en;
  logic [ADDR_W-1:0] req_addr;
  logic [BUS_W-1:0]  req_data;
  reg_sel_t          wr_sel, rd_sel;

  logic       txq_push, txq_pop, txq_full, txq_empty;
  logic       rxq_push, rxq_pop, rxq_full, rxq_empty;
  logic [7:0] rxq_head;

  logic [BUS_W-1:0] scratch_q, scratch_d;
  logic             scratch_en;

  bridge_wr_chan #(.ADDR_W(ADDR_W)) wr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .awaddr   (s_awaddr),
    .awvalid  (s_awvalid),
    .awready  (s_awready),
    .wdata    (s_wdata),
    .wstrb    (s_wstrb),
    .wvalid   (s_wvalid),
    .wready   (s_wready),
    .bresp    (s_bresp),
    .bvalid   (s_bvalid),
    .bready   (s_bready),
    .cmd_en   (cmd_en),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd_strb (cmd_strb),
    .cmd_resp (cmd_resp)
  );

  bridge_rd_chan #(.ADDR_W(ADDR_W)) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .araddr   (s_araddr),
    .arvalid  (s_arvalid),
    .arready  (s_arready),
    .rdata    (s_rdata),
    .rresp    (s_rresp),
    .rvalid   (s_rvalid),
    .rready   (s_rready),
    .req_en   (req_en),
    .req_addr (req_addr),
    .req_data (req_data)
  );

  bridge_byte_fifo #(.DEPTH(TX_DEPTH)) txq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (txq_push),
    .push_byte (cmd_data[7:0]),
    .pop       (txq_pop),
    .head_byte (tx_byte),
    .full      (txq_full),
    .empty     (txq_empty)
  );

  bridge_byte_fifo #(.DEPTH(RX_DEPTH)) rxq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rxq_push),
    .push_byte (rx_byte),
    .pop       (rxq_pop),
    .head_byte (rxq_head),
    .full      (rxq_full),
    .empty     (rxq_empty)
  );

  // Engine-side handshakes
  assign tx_valid = !txq_empty;
  assign txq_pop  = tx_valid && tx_ready;
  assign rx_ready = !rxq_full;
  assign rxq_push = rx_valid && rx_ready;

  // Write execution
  assign wr_sel     = decode_offset(32'(cmd_addr));
  assign txq_push   = cmd_en && (wr_sel == SEL_TX_BYTE) && !txq_full;
  assign scratch_en = cmd_en && (wr_sel == SEL_SCRATCH);
  assign cmd_resp   = ((wr_sel == SEL_TX_BYTE) && txq_full) ? RESP_SLVERR : RESP_OKAY;

  always_comb begin
    scratch_d = scratch_q;
    for (int lane = 0; lane < STRB_W; lane++) begin
      if (scratch_en && cmd_strb[lane]) begin
        scratch_d[8*lane +: 8] = cmd_data[8*lane +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
    end else begin
      scratch_q <= scratch_d;
    end
  end

  // Read execution
  assign rd_sel  = decode_offset(32'(req_addr));
  assign rxq_pop = req_en && (rd_sel == SEL_RX_BYTE) && !rxq_empty;

  always_comb begin
    req_data = '0;
    case (rd_sel)
      SEL_TX_STAT: req_data[0]   = !txq_full;
      SEL_RX_BYTE: req_data[7:0] = rxq_empty ? 8'h00 : rxq_head;
      SEL_RX_STAT: req_data[0]   = !rxq_empty;
      SEL_IDENT:   req_data      = ID_WORD;
      SEL_SCRATCH: req_data      = scratch_q;
      SEL_CORES:   req_data      = CORE_COUNT;
      default:     req_data      = '0;
    endcase
  end

  // R4: an offered outbound byte stays put until taken
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
  // R3: a full outbound FIFO answers with SLVERR
  a_r3_full_slverr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en && (wr_sel == SEL_TX_BYTE) && txq_full |=> s_bresp == RESP_SLVERR);
  // R10: scratch changes only on an executed scratch write
  a_r10_scratch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_en && (wr_sel == SEL_SCRATCH)) |=> $stable(scratch_q));
  // R13: reads always answer OKAY
  a_r13_rresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == RESP_OKAY);

endmodule

// File: tb/axil_byte_bridge_tb.sv
`timescale 1ns/1ps
module axil_byte_bridge_tb_top;

  localparam int          AW    = 12;
  localparam int          DEP   = 4;
  localparam logic [31:0] IDW   = 32'hC0DE_0207;
  localparam logic [31:0] CORES = 32'd6;

  logic          clk, rst_n;
  logic [AW-1:0] s_awaddr, s_araddr;
  logic          s_awvalid, s_awready, s_wvalid, s_wready;
  logic [31:0]   s_wdata, s_rdata;
  logic [3:0]    s_wstrb;
  logic [1:0]    s_bresp, s_rresp;
  logic          s_bvalid, s_bready, s_arvalid, s_arready, s_rvalid, s_rready;
  logic [7:0]    tx_byte, rx_byte;
  logic          tx_valid, tx_ready, rx_valid, rx_ready;

  axil_byte_bridge #(
    .ADDR_W(AW), .TX_DEPTH(DEP), .RX_DEPTH(DEP), .ID_WORD(IDW), .CORE_COUNT(CORES)
  ) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int fails = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_ah, m_dh, m_bv, m_rv;
  logic [11:0] m_addr;
  logic [31:0] m_data, m_scr, m_rdata;
  logic [3:0]  m_strb;
  logic [1:0]  m_bresp;
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];

  function automatic logic [31:0] word_of(input logic [11:0] a);
    return {20'd0, a[11:2], 2'b00};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ah = 0; m_dh = 0; m_bv = 0; m_rv = 0;
      m_scr = 0; m_rdata = 0; m_bresp = 0;
      txq.delete(); rxq.delete();
    end else begin
      bit aw_go, w_go, exe, ar_go, tx_go, rx_go;
      logic [31:0] rd;
      // compare every cycle
      chk("R2", "awready", s_awready, !m_ah && !m_bv);
      chk("R2", "wready",  s_wready,  !m_dh && !m_bv);
      chk("R2", "bvalid",  s_bvalid,  m_bv);
      if (m_bv) chk("R3", "bresp", s_bresp, m_bresp);
      chk("R13", "arready", s_arready, !m_rv);
      chk("R13", "rvalid",  s_rvalid,  m_rv);
      if (m_rv) begin
        chk("R13", "rdata", s_rdata, m_rdata);
        chk("R13", "rresp", s_rresp, 2'b00);
      end
      chk("R4", "tx_valid", tx_valid, txq.size() > 0);
      if (txq.size() > 0) chk("R4", "tx_byte", tx_byte, txq[0]);
      chk("R6", "rx_ready", rx_ready, rxq.size() < DEP);
      // next state
      aw_go = s_awvalid && !m_ah && !m_bv;
      w_go  = s_wvalid && !m_dh && !m_bv;
      exe   = m_ah && m_dh;
      ar_go = s_arvalid && !m_rv;
      tx_go = (txq.size() > 0) && tx_ready;
      rx_go = rx_valid && (rxq.size() < DEP);
      rd = 0;
      if (ar_go) begin
        case (word_of(s_araddr))
          32'h004: rd = {31'd0, txq.size() < DEP};
          32'h008: rd = (rxq.size() > 0) ? {24'd0, rxq[0]} : 32'd0;
          32'h00C: rd = {31'd0, rxq.size() > 0};
          32'h014: rd = IDW;
          32'h018: rd = m_scr;
          32'h01C: rd = CORES;
          default: rd = 0;
        endcase
        if (word_of(s_araddr) == 32'h008 && rxq.size() > 0) void'(rxq.pop_front());
        m_rv = 1; m_rdata = rd;
      end else if (m_rv && s_rready) m_rv = 0;
      if (tx_go) void'(txq.pop_front());
      if (rx_go) rxq.push_back(rx_byte);
      if (exe) begin
        m_bresp = 2'b00;
        if (word_of(m_addr) == 32'h000) begin
          if (txq.size() + (tx_go ? 1 : 0) < DEP) txq.push_back(m_data[7:0]);
          else m_bresp = 2'b10;
        end
        if (word_of(m_addr) == 32'h018)
          for (int b = 0; b < 4; b++) if (m_strb[b]) m_scr[8*b +: 8] = m_data[8*b +: 8];
        m_ah = 0; m_dh = 0; m_bv = 1;
      end else if (m_bv && s_bready) m_bv = 0;
      if (aw_go) begin m_ah = 1; m_addr = s_awaddr; end
      if (w_go)  begin m_dh = 1; m_data = s_wdata; m_strb = s_wstrb; end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic axw(input logic [11:0] a, input logic [31:0] d, input logic [3:0] st,
                     input int ad, input int wd, input int bd, output logic [1:0] resp);
    int c = 0;
    bit a_ok = 0, d_ok = 0, seen = 0;
    while (!(a_ok && d_ok)) begin
      s_awaddr = a; s_wdata = d; s_wstrb = st;
      s_awvalid = !a_ok && (c >= ad);
      s_wvalid  = !d_ok && (c >= wd);
      @(negedge clk);
      if (s_awvalid && s_awready) a_ok = 1;
      if (s_wvalid && s_wready) d_ok = 1;
      @(posedge clk); #1; c++;
    end
    s_awvalid = 0; s_wvalid = 0;
    while (!seen) begin
      @(negedge clk);
      if (s_bvalid) seen = 1;
    end
    repeat (bd) @(negedge clk);
    resp = s_bresp;
    s_bready = 1;
    @(posedge clk); #1;
    s_bready = 0;
  endtask

  task automatic axr(input logic [11:0] a, input int rdl, output logic [31:0] d);
    bit taken = 0, seen = 0;
    s_araddr = a; s_arvalid = 1;
    while (!taken) begin
      @(negedge clk);
      if (s_arready) taken = 1;
      @(posedge clk); #1;
    end
    s_arvalid = 0;
    while (!seen) begin
      @(negedge clk);
      if (s_rvalid) seen = 1;
    end
    repeat (rdl) @(negedge clk);
    d = s_rdata;
    s_rready = 1;
    @(posedge clk); #1;
    s_rready = 0;
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [1:0]  r;
    logic [31:0] d;
    rst_n = 0;
    s_awaddr = 0; s_awvalid = 0; s_wdata = 0; s_wstrb = 0; s_wvalid = 0; s_bready = 0;
    s_araddr = 0; s_arvalid = 0; s_rready = 0;
    tx_ready = 0; rx_byte = 0; rx_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "bvalid", s_bvalid, 0);
    chk("R1", "rvalid", s_rvalid, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "ready set", {s_awready, s_wready, s_arready, rx_ready}, 4'hF);
    @(posedge clk); #1;

    // R9, R11, R12: identification, core count, unmapped
    axr(12'h014, 0, d); chk("R9", "ident", d, IDW);
    axr(12'h01C, 0, d); chk("R11", "cores", d, CORES);
    axr(12'h010, 0, d); chk("R12", "hole 0x010", d, 0);
    axr(12'h3F0, 0, d); chk("R12", "high hole", d, 0);
    axr(12'h016, 0, d); chk("R12", "low bits ignored", d, IDW);

    // R10 scratch with strobes, R2 write orderings
    axw(12'h018, 32'hCAFE_BABE, 4'hF, 0, 0, 0, r); chk("R2", "resp both", r, 2'b00);
    axr(12'h018, 0, d); chk("R10", "scratch full", d, 32'hCAFE_BABE);
    axw(12'h018, 32'h1122_3344, 4'b0101, 0, 3, 2, r); chk("R2", "addr first", r, 2'b00);
    axr(12'h018, 0, d); chk("R10", "scratch strobe", d, 32'hCA22_BA44);
    axw(12'h01B, 32'h5566_7788, 4'b1000, 4, 0, 0, r); chk("R2", "data first", r, 2'b00);
    axr(12'h018, 2, d); chk("R10", "scratch lane3", d, 32'h5522_BA44);

    // R9, R12: writes that must change nothing
    axw(12'h014, 32'h0, 4'hF, 0, 0, 0, r); chk("R9", "ident write resp", r, 2'b00);
    axr(12'h014, 0, d); chk("R9", "ident unchanged", d, IDW);
    axw(12'h010, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, r); chk("R12", "hole write resp", r, 2'b00);
    axr(12'h018, 0, d); chk("R12", "scratch untouched", d, 32'h5522_BA44);

    // R3, R5: fill the outbound FIFO while the engine stalls
    axr(12'h004, 0, d); chk("R5", "tx room empty", d, 1);
    for (int i = 0; i < DEP; i++) begin
      axw(12'h000, 32'hABCD_0010 + i, 4'hF, i % 2, 0, 0, r);
      chk("R3", "push resp", r, 2'b00);
    end
    axw(12'h000, 32'h0000_0099, 4'hF, 0, 0, 0, r); chk("R3", "full slverr", r, 2'b10);
    axr(12'h004, 0, d); chk("R5", "tx no room", d, 0);
    // R4: drain with a stuttering engine; model checks order every cycle
    for (int i = 0; i < 12; i++) begin
      tx_ready = (i % 3 != 1);
      @(posedge clk); #1;
    end
    tx_ready = 0;
    chk("R4", "drained", tx_valid, 0);
    axr(12'h004, 0, d); chk("R5", "tx room again", d, 1);
    // R4: write and drain in the same window
    tx_ready = 1;
    axw(12'h000, 32'h0000_005A, 4'hF, 0, 0, 0, r); chk("R3", "push live", r, 2'b00);
    repeat (3) @(posedge clk); #1;
    tx_ready = 0;

    // R6, R7, R8: inbound overrun and reads
    axr(12'h00C, 0, d); chk("R8", "rx none", d, 0);
    axr(12'h008, 0, d); chk("R7", "empty read", d, 0);
    for (int i = 0; i < DEP + 2; i++) begin
      rx_valid = 1; rx_byte = 8'hA0 + 8'(i);
      @(posedge clk); #1;
    end
    rx_valid = 0;
    chk("R6", "rx full", rx_ready, 0);
    axr(12'h00C, 0, d); chk("R8", "rx waiting", d, 1);
    for (int i = 0; i < DEP; i++) begin
      axr(12'h008, i % 2, d); chk("R7", "rx byte", d, 32'h0000_00A0 + i);
    end
    axr(12'h008, 0, d); chk("R7", "rx drained", d, 0);
    axr(12'h00C, 0, d); chk("R8", "rx empty", d, 0);
    chk("R6", "rx room", rx_ready, 1);

    // R13: delayed read acceptance
    axr(12'h01C, 5, d); chk("R13", "held read", d, CORES);

    repeat (4) @(posedge clk);
    summary();
    $finish;
  end

endmodule